// File: doc/BRIEF.md
# Burst Length Limiter for Re-arbitration

This block sits next to the arbiter of one slave port and tells it when a long-running access may be broken so that other masters get a turn. It has two independent triggers.

The first trigger is a beat limit that applies only to incrementing bursts of open length. A two-bit length code, captured when the burst starts, sets an expected burst span of 4, 8 or 16 beats, or no span at all. The block counts accepted beats and raises an event each time the count reaches a whole multiple of that span. This gives the arbiter a chance to re-arbitrate at every such boundary, not only the first.

The second trigger is a clock-cycle budget that applies to every access. When an access starts, a countdown is loaded with the programmed slot limit. The countdown then drops by one each clock and stops at zero. Once the budget is used up, the next transfer-complete strobe raises an event. The access is therefore never cut in the middle of a byte, halfword or word transfer. Both events are merged into a registered, one-clock re-arbitrate pulse.

Top module: `burst_rearb_limiter`

## Requirements
- R1: After reset `rearb_o` is 0, and it stays 0 until a burst start has been accepted, whatever `beat_valid_i` and `xfer_done_i` do.
- R2: With length code 2'b00 the beat logic never produces a pulse, however many beats arrive.
- R3: With length code 2'b01, 2'b10 or 2'b11 (span 4, 8 or 16) on an incrementing burst, `rearb_o` is high for one cycle in the cycle after the accepted beat that makes the beat count equal to span, 2×span, 3×span, and so on.
- R4: The beat count is cleared on `burst_start_i`. A beat accepted in the start cycle counts as beat 1, and cycles with `beat_valid_i` low do not advance the count.
- R5: A burst whose `burst_incr_i` is 0 in its start cycle never produces a beat-derived pulse.
- R6: The length code and the burst type are captured in the start cycle. Changes to them later in the same burst have no effect.
- R7: The slot countdown loads `slot_limit_i` (L) in the start cycle and decrements once per clock. It saturates at 0 and does not wrap, so the budget is exhausted from cycle L+1 after the start cycle onward.
- R8: Budget exhaustion alone gives no pulse, and a `xfer_done_i` seen before exhaustion gives no pulse. The first `xfer_done_i` at or after exhaustion gives a pulse in the next cycle.
- R9: At most one slot-derived pulse is produced per burst. Further `xfer_done_i` strobes in the same burst are ignored.
- R10: A slot limit of 0 disables the budget for that burst.
- R11: In a cycle with `burst_start_i` high, no slot-derived event is raised, and the budget restarts from the new limit.
- R12: When a beat boundary and a slot event fall in the same cycle, `rearb_o` is a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_start_i | input | 1 | First cycle of a new access |
| beat_valid_i | input | 1 | A data beat is accepted this cycle |
| burst_incr_i | input | 1 | Access is an open-length incrementing burst (sampled at start) |
| len_sel_i | input | 2 | Span code: 00 none, 01 four, 10 eight, 11 sixteen (sampled at start) |
| slot_limit_i | input | SLOT_W | Clock-cycle budget, 0 disables (sampled at start) |
| xfer_done_i | input | 1 | Current byte/halfword/word transfer completes this cycle |
| rearb_o | output | 1 | One-cycle re-arbitrate request |

## Verification
The beat trigger is tried in three ways: with back-to-back beats for each span code, with beats broken by idle gaps, and with the code and type changed mid-burst. Together these show whether the count advances on accepted beats only, repeats at every multiple, and uses the captured configuration. The slot trigger is tried with completion strobes placed before, exactly at and after budget exhaustion, with repeated strobes, and with a zero limit. This separates an off-by-one in the countdown from a missing one-shot guard. A final pattern lines up a fourth beat with a qualifying strobe, and another restarts a burst during an exhausted budget, to check how the two triggers merge and how a start takes priority.

// File: rtl/brl_pkg.sv
package brl_pkg;

  // Span code captured at burst start
  typedef enum logic [1:0] {
    SPAN_NONE = 2'b00,
    SPAN_4    = 2'b01,
    SPAN_8    = 2'b10,
    SPAN_16   = 2'b11
  } span_code_e;

  localparam int unsigned SPAN_LSB_W = 4;

  // Low-bit mask whose all-zero pattern marks a span boundary
  function automatic logic [SPAN_LSB_W-1:0] span_mask(span_code_e code);
    logic [SPAN_LSB_W-1:0] m;
    unique case (code)
      SPAN_4:  m = 4'b0011;
      SPAN_8:  m = 4'b0111;
      SPAN_16: m = 4'b1111;
      default: m = 4'b0000;
    endcase
    return m;
  endfunction

  // True when a count value lands on a boundary of the given span
  function automatic logic on_boundary(logic [SPAN_LSB_W-1:0] cnt_lsb, span_code_e code);
    return (code != SPAN_NONE) && ((cnt_lsb & span_mask(code)) == '0);
  endfunction

endpackage

// File: rtl/brl_beat_track.sv
module brl_beat_track
  import brl_pkg::*;
#(
  parameter int unsigned BEAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              beat_i,
  input  logic              incr_i,
  input  logic [1:0]        code_i,
  output logic              beat_evt_o,
  output span_code_e        code_q_o,
  output logic              incr_q_o,
  output logic [BEAT_W-1:0] cnt_q_o
);

  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  logic [BEAT_W-1:0] cnt_q, cnt_d, cnt_inc;
  span_code_e        code_q;
  logic              incr_q;

  assign cnt_inc = cnt_q + ONE;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)
      cnt_d = beat_i ? ONE : '0;
    else if (beat_i)
      cnt_d = cnt_inc;
  end

  // Only beats inside a running burst can close a span; the start beat is beat 1
  assign beat_evt_o = !start_i && beat_i && incr_q &&
                      on_boundary(cnt_inc[SPAN_LSB_W-1:0], code_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      code_q <= SPAN_NONE;
      incr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (start_i) begin
        code_q <= span_code_e'(code_i);
        incr_q <= incr_i;
      end
    end
  end

  assign code_q_o = code_q;
  assign incr_q_o = incr_q;
  assign cnt_q_o  = cnt_q;

endmodule

// File: rtl/brl_slot_timer.sv
module brl_slot_timer #(
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SLOT_W-1:0] limit_i,
  input  logic              done_i,
  output logic              slot_evt_o,
  output logic              expired_o,
  output logic              armed_o,
  output logic [SLOT_W-1:0] cnt_q_o
);

  logic [SLOT_W-1:0] cnt_q;
  logic              armed_q;
  logic              spent_q;

  assign expired_o  = armed_q && (cnt_q == '0);
  assign slot_evt_o = !start_i && expired_o && done_i && !spent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      spent_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= limit_i;
      armed_q <= (limit_i != '0);
      spent_q <= 1'b0;
    end else begin
      if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
      if (slot_evt_o)
        spent_q <= 1'b1;
    end
  end

  assign armed_o = armed_q;
  assign cnt_q_o = cnt_q;

endmodule

// File: rtl/brl_pulse_merge.sv
module brl_pulse_merge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic beat_evt_i,
  input  logic slot_evt_i,
  output logic pulse_o
);

  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= beat_evt_i | slot_evt_i;
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/burst_rearb_limiter.sv
module burst_rearb_limiter
  import brl_pkg::*;
#(
  parameter int unsigned SLOT_W = 8,
  parameter int unsigned BEAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              burst_start_i,
  input  logic              beat_valid_i,
  input  logic              burst_incr_i,
  input  logic [1:0]        len_sel_i,
  input  logic [SLOT_W-1:0] slot_limit_i,
  input  logic              xfer_done_i,
  output logic              rearb_o
);

  // Named internal events, exposed for the bound checker
  logic              beat_evt;
  logic              slot_evt;
  logic              slot_expired;
  logic              slot_armed;
  logic [SLOT_W-1:0] slot_cnt;
  logic [BEAT_W-1:0] beat_cnt;
  span_code_e        span_q;
  logic              incr_q;

  brl_beat_track #(.BEAT_W(BEAT_W)) u_beat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (burst_start_i),
    .beat_i     (beat_valid_i),
    .incr_i     (burst_incr_i),
    .code_i     (len_sel_i),
    .beat_evt_o (beat_evt),
    .code_q_o   (span_q),
    .incr_q_o   (incr_q),
    .cnt_q_o    (beat_cnt)
  );

  brl_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (burst_start_i),
    .limit_i    (slot_limit_i),
    .done_i     (xfer_done_i),
    .slot_evt_o (slot_evt),
    .expired_o  (slot_expired),
    .armed_o    (slot_armed),
    .cnt_q_o    (slot_cnt)
  );

  brl_pulse_merge u_merge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_evt_i (beat_evt),
    .slot_evt_i (slot_evt),
    .pulse_o    (rearb_o)
  );

endmodule

// File: rtl/brl_chk.sv
module brl_chk
  import brl_pkg::*;
#(
  parameter int unsigned SLOT_W = 8,
  parameter int unsigned BEAT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              burst_start_i,
  input logic              beat_valid_i,
  input logic              xfer_done_i,
  input logic [SLOT_W-1:0] slot_limit_i,
  input logic              rearb_o,
  input logic              beat_evt,
  input logic              slot_evt,
  input logic              slot_expired,
  input logic              slot_armed,
  input logic [SLOT_W-1:0] slot_cnt,
  input logic [BEAT_W-1:0] beat_cnt,
  input span_code_e        span_q,
  input logic              incr_q
);

  // R12
  pulse_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearb_o |-> $past(beat_evt || slot_evt));

  // R2
  no_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (span_q == SPAN_NONE) |-> !beat_evt);

  // R5
  non_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !incr_q |-> !beat_evt);

  // R4
  beat_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_evt |-> beat_valid_i && !burst_start_i);

  // R4
  beat_cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!burst_start_i && !beat_valid_i) |=> $stable(beat_cnt));

  // R7
  slot_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_start_i |=> (slot_cnt == $past(slot_limit_i)));

  // R7
  slot_saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!burst_start_i && slot_cnt == '0) |=> (slot_cnt == '0));

  // R7
  slot_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!burst_start_i && slot_cnt != '0) |=> (slot_cnt == $past(slot_cnt) - 1'b1));

  // R8
  slot_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_evt |-> xfer_done_i && slot_expired);

  // R10
  slot_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_armed |-> !slot_evt);

  // R11
  start_blocks_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_start_i |-> !slot_evt);

  // R9
  slot_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_evt && !burst_start_i) |=> (!slot_evt || burst_start_i) || !$past(slot_evt));

endmodule

bind burst_rearb_limiter brl_chk #(.SLOT_W(SLOT_W), .BEAT_W(BEAT_W)) u_brl_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .burst_start_i (burst_start_i),
  .beat_valid_i  (beat_valid_i),
  .xfer_done_i   (xfer_done_i),
  .slot_limit_i  (slot_limit_i),
  .rearb_o       (rearb_o),
  .beat_evt      (beat_evt),
  .slot_evt      (slot_evt),
  .slot_expired  (slot_expired),
  .slot_armed    (slot_armed),
  .slot_cnt      (slot_cnt),
  .beat_cnt      (beat_cnt),
  .span_q        (span_q),
  .incr_q        (incr_q)
);

// File: tb/burst_rearb_limiter_tb.sv
module burst_rearb_limiter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SLOT_W     = 8;
  localparam int WATCHDOG   = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0, beat = 1'b0, incr = 1'b0, done = 1'b0;
  logic [1:0]        len = 2'b00;
  logic [SLOT_W-1:0] limit = '0;
  logic              rearb;

  int    n_checks = 0, n_fail = 0, pulses = 0;
  string tag = "R1";
  bit    finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_rearb_limiter #(.SLOT_W(SLOT_W), .BEAT_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .burst_start_i(start), .beat_valid_i(beat),
    .burst_incr_i(incr), .len_sel_i(len), .slot_limit_i(limit),
    .xfer_done_i(done), .rearb_o(rearb)
  );

  // Behavioural reference: integers, evaluated on each edge from the requirements
  int m_beats = 0, m_span = 0, m_slot = 0;
  bit m_incr = 0, m_armed = 0, m_spent = 0, m_exp = 0;

  always @(posedge clk) begin
    bit ev_beat, ev_slot;
    if (!rst_n) begin
      m_beats = 0; m_span = 0; m_slot = 0;
      m_incr = 0; m_armed = 0; m_spent = 0; m_exp = 0;
    end else begin
      ev_beat = 0; ev_slot = 0;
      if (start) begin
        m_span  = (len == 2'd1) ? 4 : (len == 2'd2) ? 8 : (len == 2'd3) ? 16 : 0;
        m_incr  = incr;
        m_beats = beat ? 1 : 0;
        m_slot  = int'(limit);
        m_armed = (limit != 0);
        m_spent = 0;
      end else begin
        if (m_armed && m_slot == 0 && done && !m_spent) begin
          ev_slot = 1; m_spent = 1;
        end
        if (m_slot > 0) m_slot--;
        if (beat) begin
          m_beats++;
          if (m_incr && m_span != 0 && (m_beats % m_span) == 0) ev_beat = 1;
        end
      end
      m_exp = ev_beat || ev_slot;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      n_checks++;
      if (rearb !== m_exp) begin
        n_fail++;
        $display("FAIL %s rearb_o actual=%0b expected=%0b at %0t", tag, rearb, m_exp, $time);
      end
      if (rearb === 1'b1) pulses++;
    end
  end

  task automatic drive(input bit s, input bit b, input bit d);
    start = s; beat = b; done = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0);
  endtask

  task automatic check_pulses(input string t, input int exp);
    n_checks++;
    if (pulses != exp) begin
      n_fail++;
      $display("FAIL %s pulse count actual=%0d expected=%0d", t, pulses, exp);
    end
    pulses = 0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    n_checks++;
    if (rearb !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset rearb_o actual=%0b expected=0", rearb);
    end
    rst_n = 1'b1;

    // R1: activity without any start
    tag = "R1"; incr = 1; len = 2'd1; limit = 8'd1;
    for (int i = 0; i < 12; i++) drive(0, 1, i[0]);
    idle(2); check_pulses("R1", 0);

    // R3: span 4, continuous, 20 beats
    tag = "R3"; incr = 1; len = 2'd1; limit = 0;
    drive(1, 1, 0);
    for (int i = 0; i < 19; i++) drive(0, 1, 0);
    idle(2); check_pulses("R3", 5);

    // R4: span 8 with gaps, 24 beats, start cycle without beat
    tag = "R4"; len = 2'd2;
    drive(1, 0, 0);
    for (int i = 0; i < 48; i++) drive(0, i[0], 0);
    idle(2); check_pulses("R4", 3);

    // R3: span 16, 40 beats
    tag = "R3"; len = 2'd3;
    drive(1, 1, 0);
    for (int i = 0; i < 39; i++) drive(0, 1, 0);
    idle(2); check_pulses("R3", 2);

    // R2: no span
    tag = "R2"; len = 2'd0;
    drive(1, 1, 0);
    for (int i = 0; i < 40; i++) drive(0, 1, 0);
    idle(2); check_pulses("R2", 0);

    // R5: non-incrementing burst
    tag = "R5"; len = 2'd1; incr = 0;
    drive(1, 1, 0);
    for (int i = 0; i < 15; i++) drive(0, 1, 0);
    idle(2); check_pulses("R5", 0);

    // R6: config changed mid-burst is ignored
    tag = "R6"; incr = 1; len = 2'd1;
    drive(1, 1, 0);
    drive(0, 1, 0);
    incr = 0; len = 2'd0;
    for (int i = 0; i < 10; i++) drive(0, 1, 0);
    idle(2); check_pulses("R6", 3);

    // R7/R8: limit 5, strobes before and after exhaustion
    tag = "R8"; incr = 0; limit = 8'd5;
    drive(1, 0, 0);                        // cycle 0
    drive(0, 0, 0); drive(0, 0, 0);        // 1,2
    drive(0, 0, 1);                        // 3: early
    drive(0, 0, 0);                        // 4
    drive(0, 0, 1);                        // 5: still early
    tag = "R7";
    drive(0, 0, 0); drive(0, 0, 0); drive(0, 0, 0);  // 6..8 exhausted, no strobe
    drive(0, 0, 1);                        // 9: fires
    tag = "R9";
    drive(0, 0, 0); drive(0, 0, 1); drive(0, 0, 1);
    idle(2); check_pulses("R9", 1);

    // R7: strobe exactly at cycle L+1
    tag = "R7"; limit = 8'd3;
    drive(1, 0, 0);
    drive(0, 0, 1); drive(0, 0, 1); drive(0, 0, 1);   // 1..3 early
    drive(0, 0, 1);                                   // 4 = L+1 fires
    idle(2); check_pulses("R7", 1);

    // R10: zero limit disables
    tag = "R10"; limit = 0;
    drive(1, 0, 1);
    for (int i = 0; i < 10; i++) drive(0, 0, 1);
    idle(2); check_pulses("R10", 0);

    // R11: restart while exhausted, strobe in start cycle
    tag = "R11"; limit = 8'd1;
    drive(1, 0, 0); idle(3);
    drive(1, 0, 1);                // start wins, no event
    drive(0, 0, 1);                // cycle 1: counter still 1
    drive(0, 0, 1);                // cycle 2: fires
    idle(2); check_pulses("R11", 1);

    // R12: 4th beat and qualifying strobe in the same cycle
    tag = "R12"; incr = 1; len = 2'd1; limit = 8'd2;
    drive(1, 1, 0);
    drive(0, 1, 0); drive(0, 1, 0);
    drive(0, 1, 1);                // beat 4 + exhausted strobe
    idle(2); check_pulses("R12", 1);

    finish_run();
  end

endmodule